// File: doc/BRIEF.md
# Shared-Channel Read-Lock Mutex

This block arbitrates a set of shared channels, each claimed by two parties: software on a memory-mapped register bus and an autonomous hardware agent. The agent asks for its channel with a request line and holds it through a registered grant. Software first sets the enable bit of the channel's control word. From then on, a bus read of that word is a request for the lock. A read that returns the lock-status bit as 0 means software now holds the channel. Software gives the channel back by writing a one to the status bit, with the enable bit kept at one.

There is one control word for each channel. Each word sits at its own address, and the words are spaced 0x100 apart from a base address. While a channel's mutex is disabled, reads of its word have no side effect, so software can read-modify-write the word safely before it enables the lock. While the mutex is disabled, the agent gets the channel whenever it asks for it. When a write and a read target the same cycle, the write takes effect and the read has no locking effect.

Top module: `hw_mutex_reg`

## Requirements
- R1: After reset every channel is disabled, owned by nobody (idle high, grant and software-owner low), and a read of any word returns 0.
- R2: In the control word, bit 31 is the enable, bit 30 reads 1 whenever the channel is held by either party, and bits 29:0 are stored by writes and read back unchanged.
- R3: A read of an enabled, free channel returns status 0, and software owns the channel from the next cycle. Its ownership is sticky until a write changes it, so a second read returns status 1.
- R4: A read while the agent holds the channel returns status 1 and does not change ownership. The agent keeps the grant while its request stays high.
- R5: When the agent's request and a software read reach an enabled, free channel in the same cycle, software wins. The agent is granted one cycle after the release, if its request is still high.
- R6: A write with bit 31 = 1 and bit 30 = 1 from the software owner frees the channel in the next cycle. A write with bit 30 = 0 keeps software's ownership. A release write while the agent holds the channel leaves the grant unchanged.
- R7: While a channel is disabled, reads have no locking effect, software never owns it, and the agent's grant follows its request with one cycle of delay.
- R8: A write with bit 31 = 0 drops software ownership at once. If the agent is requesting, it is granted in the next cycle.
- R9: When the agent drops its request, its grant falls in the next cycle and the channel becomes idle.
- R10: Channel c answers only at address BASE_ADDR + c*0x100. Other addresses read as 0, writes to them change nothing, and channels do not affect one another.
- R11: Software ownership and agent grant are never both high on one channel, and idle is high exactly when neither is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, takes priority over bus_rd |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word in the same cycle, 0 otherwise |
| agent_req | input | N_CH | Hardware agent request, one bit per channel |
| agent_gnt | output | N_CH | Agent owns the channel |
| sw_owner | output | N_CH | Software owns the channel |
| chan_idle | output | N_CH | Channel owned by nobody |

## Verification
All ownership lives in one small state per channel, so a wrong owner shows at the ports at the next clock edge. It appears on the grant, owner and idle lines and on the status bit of the next read. The bench runs a behavioural model next to the design and compares every output on every clock. Any divergence caused by a lost release, a double grant or a read with a stray side effect is therefore reported in the cycle it first becomes visible. Addresses that fall between channels, or beyond the last one, are exercised so that decode errors are caught on the channel they leak into.

// File: rtl/hw_mutex_reg.sv
module hw_mutex_reg #(
  parameter int N_CH = 4,
  parameter int ADDR_W = 20,
  parameter int unsigned BASE_ADDR = 32'h6402C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CH-1:0]   agent_req,
  output logic [N_CH-1:0]   agent_gnt,
  output logic [N_CH-1:0]   sw_owner,
  output logic [N_CH-1:0]   chan_idle
);
  localparam int unsigned STRIDE = 32'h100;
  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_SW   = 2'd1;
  localparam logic [1:0] OWN_HW   = 2'd2;

  logic [N_CH-1:0] en_q;
  logic [31:0]     word [N_CH];
  logic [N_CH-1:0] hit;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic        en_r;
    logic [1:0]  own_r;
    logic [29:0] rsv_r;
    logic        rd_c, wr_c;

    assign hit[c] = (bus_addr == ADDR_W'(BASE_ADDR + c * STRIDE));
    assign rd_c   = bus_rd & ~bus_wr & hit[c];
    assign wr_c   = bus_wr & hit[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        own_r <= OWN_NONE;
        rsv_r <= '0;
      end else if (wr_c) begin
        en_r  <= bus_wdata[31];
        rsv_r <= bus_wdata[29:0];
        if (!bus_wdata[31])
          own_r <= agent_req[c] ? OWN_HW : OWN_NONE;
        else if (own_r == OWN_SW && bus_wdata[30])
          own_r <= OWN_NONE;
        else if (own_r == OWN_NONE && agent_req[c])
          own_r <= OWN_HW;
        else if (own_r == OWN_HW && !agent_req[c])
          own_r <= OWN_NONE;
      end else if (!en_r) begin
        own_r <= agent_req[c] ? OWN_HW : OWN_NONE;
      end else begin
        case (own_r)
          OWN_NONE: if (rd_c) own_r <= OWN_SW;
                    else if (agent_req[c]) own_r <= OWN_HW;
          OWN_HW:   if (!agent_req[c]) own_r <= OWN_NONE;
          default:  own_r <= own_r;
        endcase
      end
    end

    assign en_q[c]      = en_r;
    assign word[c]      = {en_r, own_r != OWN_NONE, rsv_r};
    assign agent_gnt[c] = own_r == OWN_HW;
    assign sw_owner[c]  = own_r == OWN_SW;
    assign chan_idle[c] = own_r == OWN_NONE;
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (bus_rd && hit[c]) bus_rdata = word[c];
  end
endmodule

// File: rtl/hw_mutex_reg_chk.sv
module hw_mutex_reg_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [N_CH-1:0] agent_req,
  input logic [N_CH-1:0] agent_gnt,
  input logic [N_CH-1:0] sw_owner,
  input logic [N_CH-1:0] chan_idle,
  input logic [N_CH-1:0] en_q
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_owner & agent_gnt) == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_a
    a_r9_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
      agent_gnt[c] && !agent_req[c] |=> !agent_gnt[c]);
    a_r4_hw_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      agent_gnt[c] && agent_req[c] |=> agent_gnt[c]);
    a_r3_sw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sw_owner[c] && !bus_wr |=> sw_owner[c]);
    a_r7_no_sw_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |-> !sw_owner[c]);
    a_r11_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
      chan_idle[c] |-> !sw_owner[c] && !agent_gnt[c]);
  end
endmodule

bind hw_mutex_reg hw_mutex_reg_chk #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .agent_req(agent_req),
  .agent_gnt(agent_gnt), .sw_owner(sw_owner), .chan_idle(chan_idle),
  .en_q(en_q)
);

// File: tb/hw_mutex_reg_tb_top.sv
`timescale 1ns/1ps
module hw_mutex_reg_tb_top;
  localparam int N = 4;
  localparam int AW = 20;
  localparam logic [AW-1:0] A0 = 20'h6402C;
  localparam logic [AW-1:0] A1 = 20'h6412C;
  localparam logic [AW-1:0] A2 = 20'h6422C;
  localparam logic [AW-1:0] A3 = 20'h6432C;
  localparam logic [AW-1:0] AX = 20'h6442C;
  localparam logic [AW-1:0] AY = 20'h64030;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] agent_req = '0, agent_gnt, sw_owner, chan_idle;

  int checks = 0, errors = 0;
  int m_own [N];
  bit m_en [N];
  bit [29:0] m_rsv [N];
  logic [31:0] rv;

  always #10 clk = ~clk;

  hw_mutex_reg dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .agent_req(agent_req),
    .agent_gnt(agent_gnt), .sw_owner(sw_owner), .chan_idle(chan_idle));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(int c);
    return AW'(32'h6402C + c * 256);
  endfunction

  task automatic check_state(string tag);
    logic [N-1:0] eg, es, ei;
    for (int c = 0; c < N; c++) begin
      eg[c] = m_own[c] == 2;
      es[c] = m_own[c] == 1;
      ei[c] = m_own[c] == 0;
    end
    chk({tag, " grant"}, 32'(agent_gnt), 32'(eg));
    chk({tag, " owner"}, 32'(sw_owner), 32'(es));
    chk({tag, " idle"}, 32'(chan_idle), 32'(ei));
  endtask

  task automatic step(string tag, bit rd, bit wr, logic [AW-1:0] a,
                      logic [31:0] d, logic [N-1:0] req, output logic [31:0] rdv);
    logic [31:0] exp;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; agent_req = req;
    #1;
    exp = '0;
    for (int c = 0; c < N; c++)
      if (rd && a == addr_of(c)) exp = {m_en[c], m_own[c] != 0, m_rsv[c]};
    rdv = bus_rdata;
    chk({tag, " rdata"}, bus_rdata, exp);
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      bit h = (a == addr_of(c));
      if (wr && h) begin
        m_rsv[c] = d[29:0];
        if (!d[31]) m_own[c] = req[c] ? 2 : 0;
        else if (m_own[c] == 1 && d[30]) m_own[c] = 0;
        else if (m_own[c] == 0 && req[c]) m_own[c] = 2;
        else if (m_own[c] == 2 && !req[c]) m_own[c] = 0;
        m_en[c] = d[31];
      end else if (!m_en[c]) m_own[c] = req[c] ? 2 : 0;
      else if (m_own[c] == 0) begin
        if (rd && h) m_own[c] = 1;
        else if (req[c]) m_own[c] = 2;
      end else if (m_own[c] == 2 && !req[c]) m_own[c] = 0;
    end
    #2;
    check_state(tag);
  endtask

  task automatic idle_step(string tag, logic [N-1:0] req);
    logic [31:0] dummy;
    step(tag, 0, 0, A0, 0, req, dummy);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int c = 0; c < N; c++) begin m_own[c] = 0; m_en[c] = 0; m_rsv[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    #1; chk("R1 idle", 32'(chan_idle), 32'hF);
    chk("R1 grant", 32'(agent_gnt), 0);
    step("R1", 1, 0, A0, 0, 0, rv); chk("R1 read", rv, 0);

    // R7 disabled channel
    idle_step("R7", 4'b0001);
    chk("R7 grant follows", 32'(agent_gnt[0]), 1);
    step("R7", 1, 0, A0, 0, 4'b0001, rv); chk("R7 status hw", rv, 32'h4000_0000);
    chk("R7 no sw", 32'(sw_owner[0]), 0);
    idle_step("R9", 0); chk("R9 drop", 32'(chan_idle[0]), 1);
    step("R7", 1, 0, A0, 0, 0, rv); chk("R7 no lock", 32'(sw_owner[0]), 0);

    // R2 / R3
    step("R2", 0, 1, A0, 32'h8000_1234, 0, rv);
    step("R2", 1, 0, A0, 0, 0, rv); chk("R3 acquire read", rv, 32'h8000_1234);
    chk("R3 owner", 32'(sw_owner[0]), 1);
    step("R3", 1, 0, A0, 0, 0, rv); chk("R3 sticky", rv, 32'hC000_1234);

    // R4 / R6
    idle_step("R6", 4'b0001); chk("R6 pending", 32'(agent_gnt[0]), 0);
    step("R6", 0, 1, A0, 32'h8000_1234, 4'b0001, rv);
    chk("R6 keep", 32'(sw_owner[0]), 1);
    step("R6", 0, 1, A0, 32'hC000_1234, 4'b0001, rv);
    chk("R6 freed", 32'(chan_idle[0]), 1);
    idle_step("R6", 4'b0001); chk("R6 agent next", 32'(agent_gnt[0]), 1);
    step("R4", 1, 0, A0, 0, 4'b0001, rv); chk("R4 busy", rv, 32'hC000_1234);
    chk("R4 no sw", 32'(sw_owner[0]), 0);
    step("R6", 0, 1, A0, 32'hC000_1234, 4'b0001, rv);
    chk("R6 hw kept", 32'(agent_gnt[0]), 1);
    idle_step("R9", 0); chk("R9 idle", 32'(chan_idle[0]), 1);

    // R5 tie
    step("R5", 0, 1, A1, 32'h8000_0000, 0, rv);
    step("R5", 1, 0, A1, 0, 4'b0010, rv); chk("R5 read free", rv, 32'h8000_0000);
    chk("R5 sw wins", 32'(sw_owner[1]), 1);
    chk("R5 agent waits", 32'(agent_gnt[1]), 0);
    step("R5", 0, 1, A1, 32'hC000_0000, 4'b0010, rv);
    idle_step("R5", 4'b0010); chk("R5 agent after", 32'(agent_gnt[1]), 1);
    idle_step("R9", 0);

    // R8 disable while sw owns
    step("R8", 0, 1, A2, 32'h8000_0000, 0, rv);
    step("R8", 1, 0, A2, 0, 0, rv);
    chk("R8 owned", 32'(sw_owner[2]), 1);
    step("R8", 0, 1, A2, 0, 4'b0100, rv);
    chk("R8 sw drop", 32'(sw_owner[2]), 0);
    chk("R8 agent", 32'(agent_gnt[2]), 1);
    idle_step("R9", 0);

    // R10 decode
    step("R10", 0, 1, AX, 32'hFFFF_FFFF, 0, rv);
    step("R10", 0, 1, AY, 32'hFFFF_FFFF, 0, rv);
    step("R10", 1, 0, AX, 0, 0, rv); chk("R10 beyond", rv, 0);
    step("R10", 1, 0, A3, 0, 0, rv); chk("R10 ch3 clean", rv, 0);
    step("R10", 1, 0, A0, 0, 0, rv); chk("R10 ch0 intact", rv, 32'h8000_1234);

    // R11 pseudo-random traffic against the model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[4:2])
        3'd0: a = A0; 3'd1: a = A1; 3'd2: a = A2; 3'd3: a = A3;
        3'd4: a = AX; default: a = addr_of(int'(lfsr[6:5]));
      endcase
      d = {lfsr[7] | lfsr[8], lfsr[9], lfsr[29:0] ^ 30'h155};
      step("R11", lfsr[10] & lfsr[11], lfsr[12] & lfsr[13] & lfsr[14],
           a, d, lfsr[18:15], rv);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule